// File: doc/BRIEF.md
# ADC Serial Timing and Power-Mode Controller

This block is the digital sequencer of a sampling converter with a serial output. A rising edge on the start strobe latches the parallel sample that stands in for the quantizer. Once the part is active, that same edge opens an output frame carrying the result of the conversion before it. Each rising edge of the external serial clock moves the frame on by one bit, sign bit first. When no word is being driven, the data pin is released to high impedance, shown here as a low output enable.

The same start strobe also carries requests for low power. A run of start edges with no serial-clock edge between them is counted. A count of two puts the part into nap. A third edge brings it back to active and starts a conversion. A count of four puts it into sleep, where start edges are ignored. Any serial-clock edge, rising or falling, wakes the part from nap or sleep and clears the count.

Both strobes are sampled in the system clock domain through a parameterised synchronizer and then edge-detected.

Top module: `adc_serial_ctrl`

## Requirements
- R1: After reset the part is active (`active_o`=1, `nap_o`=0, `sleep_o`=0), the data enable is low, the data bit is 0 and the held result is zero.
- R2: A start edge accepted outside sleep latches `sample_i`. The frame opened by the next accepted, active-leaving start edge carries that latched word, so output lags by one conversion. The first frame after reset carries zero.
- R3: An accepted start edge that leaves the part active raises `sdo_en_o` and presents bit SAMPLE_W-1 (the two's complement sign) on `sdo_o`. After k serial-clock rises it presents bit SAMPLE_W-1-k, unchanged from the latched word.
- R4: After SAMPLE_W serial-clock rises in a frame, `sdo_en_o` and `sdo_o` are 0. Further serial-clock edges do not re-enable the pin.
- R5: The NAP_PULSES-th (default 2) start edge with no serial-clock edge since the count was cleared gives nap: `nap_o`=1 and the pin released.
- R6: In nap, one more start edge with a static serial clock returns the part to active and opens a frame with the word latched by the previous edge.
- R7: The SLEEP_PULSES-th (default 4) start edge with no serial-clock edge since the count was cleared gives sleep: `sleep_o`=1 and the pin released.
- R8: In sleep, start edges are ignored: the mode stays sleep, the pin stays released and the held word is not replaced.
- R9: Any serial-clock edge, rising or falling, in nap or sleep returns the part to active and clears the pulse count.
- R10: When a serial-clock edge and a start edge are detected in the same cycle, the serial-clock edge is applied first. The part wakes, the count restarts at one, and the start edge is accepted and opens a frame; the frame load beats the shift.
- R11: Conversions separated by serial-clock activity never change the mode away from active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_i | input | 1 | Conversion-start strobe |
| sck_i | input | 1 | External serial clock |
| sample_i | input | SAMPLE_W | Two's complement sample standing in for the quantizer |
| sdo_o | output | 1 | Serial data bit, 0 when released |
| sdo_en_o | output | 1 | Data pin drive enable; low means high impedance |
| active_o | output | 1 | Part is converting normally |
| nap_o | output | 1 | Part is in nap |
| sleep_o | output | 1 | Part is in sleep |

## Verification
A serial-clock edge and a start edge can be detected in the same cycle. That cycle could both wake the part and count a burst pulse, and it could both shift an open frame and load a new one. The bench puts the part to sleep with a four-edge burst, then raises the start strobe and the serial clock on the same clock. It then checks three things: the mode is active, the pin shows the sign bit of the word latched before sleep, and that word then streams out complete. The bench also checks that the sample given on the coincident edge arrives in the following frame, which shows the edge was accepted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      MODE_ACTIVE = 2'd0,
      MODE_NAP    = 2'd1,
      MODE_SLEEP  = 2'd2
   } pwr_mode_t;
endpackage

// File: rtl/adc_edge_detect.sv
module adc_edge_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic synced;
   logic last_q;

   if (STAGES < 0) begin : g_bad_stages
      $error("adc_edge_detect: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign synced = din;
   end else begin : g_sync
      logic [STAGES-1:0] chain_q;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign synced = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= synced;
   end

   assign rise = synced & ~last_q;
   assign fall = ~synced & last_q;
endmodule

// File: rtl/adc_power_fsm.sv
module adc_power_fsm
   import adc_seq_pkg::*;
#(
   parameter int NAP_PULSES   = 2,
   parameter int SLEEP_PULSES = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      conv_rise,
   input  logic      sck_edge,
   output pwr_mode_t mode,
   output logic      accept,
   output logic      arm
);
   localparam int CW = $clog2(SLEEP_PULSES + 1);
   localparam logic [CW-1:0] NAP_C   = CW'(NAP_PULSES);
   localparam logic [CW-1:0] SLEEP_C = CW'(SLEEP_PULSES);

   if (NAP_PULSES < 2) begin : g_bad_nap
      $error("adc_power_fsm: NAP_PULSES must be at least 2");
   end
   if (SLEEP_PULSES < NAP_PULSES + 2) begin : g_bad_sleep
      $error("adc_power_fsm: SLEEP_PULSES must exceed NAP_PULSES by 2");
   end

   pwr_mode_t      mode_q, mode_w, mode_n;
   logic [CW-1:0]  cnt_q, cnt_w, cnt_n;

   always_comb begin
      // serial-clock activity is applied before the start edge
      mode_w = sck_edge ? MODE_ACTIVE : mode_q;
      cnt_w  = sck_edge ? '0 : cnt_q;
      accept = conv_rise && (mode_w != MODE_SLEEP);
      mode_n = mode_w;
      cnt_n  = cnt_w;
      if (accept) begin
         cnt_n = cnt_w + 1'b1;
         if (cnt_n == SLEEP_C)    mode_n = MODE_SLEEP;
         else if (cnt_n == NAP_C) mode_n = MODE_NAP;
         else                     mode_n = MODE_ACTIVE;
      end
      arm = accept && (mode_n == MODE_ACTIVE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ACTIVE;
         cnt_q  <= '0;
      end else begin
         mode_q <= mode_n;
         cnt_q  <= cnt_n;
      end
   end

   assign mode = mode_q;

   // R9: a serial-clock edge always leaves the part active
   a_r9_wake_active: assert property (@(posedge clk) disable iff (!rst_n)
      sck_edge |=> (mode_q == MODE_ACTIVE));
   // R8: sleep persists while the serial clock is quiet
   a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SLEEP && !sck_edge) |=> (mode_q == MODE_SLEEP));
   // R10: coincident edges restart the count at one
   a_r10_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_rise && sck_edge) |=> (cnt_q == CW'(1)));
   // R7: the count never runs past the sleep threshold
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= SLEEP_C);
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample_i,
   input  logic         capture,
   input  logic         arm,
   input  logic         shift,
   output logic         sdo,
   output logic         sdo_en
);
   localparam int LW = $clog2(W + 1);
   localparam logic [LW-1:0] FULL = LW'(W);

   if (W < 2) begin : g_bad_width
      $error("adc_result_shifter: W must be at least 2");
   end

   logic [W-1:0]  pending_q;
   logic [W-1:0]  shreg_q;
   logic [LW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= '0;
         shreg_q   <= '0;
         left_q    <= '0;
      end else begin
         if (capture) pending_q <= sample_i;
         if (arm) begin
            shreg_q <= pending_q;
            left_q  <= FULL;
         end else if (capture) begin
            left_q  <= '0;
         end else if (shift && left_q != '0) begin
            shreg_q <= {shreg_q[W-2:0], 1'b0};
            left_q  <= left_q - 1'b1;
         end
      end
   end

   assign sdo_en = (left_q != '0);
   assign sdo    = sdo_en & shreg_q[W-1];

   // R8: the held word changes only on an accepted start edge
   a_r8_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(pending_q));
   // R3: the pin only starts driving after a frame load
   a_r3_drive_from_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_en) |-> $past(arm));
   // R10: a load beats a shift in the same cycle
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && shift) |=> (left_q == FULL));
   // R4: an idle pin is not re-enabled by serial-clock rises
   a_r4_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdo_en && !arm) |=> !sdo_en);
endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
   import adc_seq_pkg::*;
#(
   parameter int SAMPLE_W     = 14,
   parameter int SYNC_STAGES  = 2,
   parameter int NAP_PULSES   = 2,
   parameter int SLEEP_PULSES = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_i,
   input  logic                sck_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic                sdo_o,
   output logic                sdo_en_o,
   output logic                active_o,
   output logic                nap_o,
   output logic                sleep_o
);
   logic      conv_rise, conv_fall_unused;
   logic      sck_rise, sck_fall;
   logic      sck_edge;
   logic      accept, arm;
   pwr_mode_t mode;

   adc_edge_detect #(.STAGES(SYNC_STAGES)) u_conv_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (conv_i),
      .rise (conv_rise),
      .fall (conv_fall_unused)
   );

   adc_edge_detect #(.STAGES(SYNC_STAGES)) u_sck_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (sck_i),
      .rise (sck_rise),
      .fall (sck_fall)
   );

   assign sck_edge = sck_rise | sck_fall;

   adc_power_fsm #(
      .NAP_PULSES  (NAP_PULSES),
      .SLEEP_PULSES(SLEEP_PULSES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_rise(conv_rise),
      .sck_edge (sck_edge),
      .mode     (mode),
      .accept   (accept),
      .arm      (arm)
   );

   adc_result_shifter #(.W(SAMPLE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sample_i(sample_i),
      .capture (accept),
      .arm     (arm),
      .shift   (sck_rise),
      .sdo     (sdo_o),
      .sdo_en  (sdo_en_o)
   );

   assign active_o = (mode == MODE_ACTIVE);
   assign nap_o    = (mode == MODE_NAP);
   assign sleep_o  = (mode == MODE_SLEEP);

   // R1: exactly one mode indication at a time
   a_r1_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({active_o, nap_o, sleep_o}));
   // R5: the pin is released throughout nap
   a_r5_nap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      nap_o |-> !sdo_en_o);
   // R7: the pin is released throughout sleep
   a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> !sdo_en_o);
endmodule

// File: tb/test_adc_serial_ctrl.sv
module test_adc_serial_ctrl;
   localparam int W = 14;
   localparam int HOLD = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         conv_i = 1'b0;
   logic         sck_i = 1'b0;
   logic [W-1:0] sample_i = '0;
   logic         sdo_o, sdo_en_o, active_o, nap_o, sleep_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adc_serial_ctrl #(.SAMPLE_W(W)) i_adc_serial_ctrl (
      .clk(clk), .rst_n(rst_n), .conv_i(conv_i), .sck_i(sck_i),
      .sample_i(sample_i), .sdo_o(sdo_o), .sdo_en_o(sdo_en_o),
      .active_o(active_o), .nap_o(nap_o), .sleep_o(sleep_o));

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic conv_pulse(input logic [W-1:0] val);
      sample_i = val;
      conv_i = 1'b1;
      wait_n(HOLD);
      conv_i = 1'b0;
      wait_n(HOLD);
   endtask

   task automatic sck_pulse();
      sck_i = 1'b1;
      wait_n(HOLD);
      sck_i = 1'b0;
      wait_n(HOLD);
   endtask

   task automatic check_mode(input string tag, input logic a, input logic n, input logic s);
      check(tag, {29'd0, active_o, nap_o, sleep_o}, {29'd0, a, n, s});
   endtask

   task automatic read_frame(input string tag, input logic [W-1:0] exp);
      for (int k = 0; k < W; k++) begin
         check({tag, " enable"}, {31'd0, sdo_en_o}, 32'd1);
         check({tag, " bit"}, {31'd0, sdo_o}, {31'd0, exp[W-1-k]});
         sck_pulse();
      end
      check("R4 released after frame", {31'd0, sdo_en_o}, 32'd0);
   endtask

   task automatic t_reset();
      check_mode("R1 reset mode", 1'b1, 1'b0, 1'b0);
      check("R1 reset enable", {31'd0, sdo_en_o}, 32'd0);
      check("R1 reset data", {31'd0, sdo_o}, 32'd0);
   endtask

   task automatic t_stream();
      conv_pulse(14'h2ABC);
      read_frame("R2 first frame zero", 14'h0000);
      check_mode("R11 active", 1'b1, 1'b0, 1'b0);
      conv_pulse(14'h0123);
      read_frame("R3 word 2ABC", 14'h2ABC);
      conv_pulse(14'h3FFF);
      read_frame("R2 latency word 0123", 14'h0123);
      sck_pulse();
      sck_pulse();
      check("R4 extra clocks idle", {31'd0, sdo_en_o}, 32'd0);
      check("R4 extra clocks data", {31'd0, sdo_o}, 32'd0);
      check_mode("R11 still active", 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_nap_resume();
      conv_pulse(14'h1111);
      check_mode("R5 one pulse active", 1'b1, 1'b0, 1'b0);
      conv_pulse(14'h2222);
      check_mode("R5 nap after two", 1'b0, 1'b1, 1'b0);
      check("R5 nap released", {31'd0, sdo_en_o}, 32'd0);
      conv_pulse(14'h0F0F);
      check_mode("R6 third pulse active", 1'b1, 1'b0, 1'b0);
      read_frame("R6 resume frame", 14'h2222);
   endtask

   task automatic t_nap_wake();
      conv_pulse(14'h0AAA);
      conv_pulse(14'h1555);
      check_mode("R5 nap again", 1'b0, 1'b1, 1'b0);
      sck_pulse();
      check_mode("R9 wake from nap", 1'b1, 1'b0, 1'b0);
      check("R9 no frame on wake", {31'd0, sdo_en_o}, 32'd0);
      conv_pulse(14'h0001);
      read_frame("R9 frame after nap wake", 14'h1555);
   endtask

   task automatic t_sleep();
      conv_pulse(14'h0101);
      conv_pulse(14'h0202);
      conv_pulse(14'h0303);
      check_mode("R6 three pulses active", 1'b1, 1'b0, 1'b0);
      conv_pulse(14'h2468);
      check_mode("R7 sleep after four", 1'b0, 1'b0, 1'b1);
      check("R7 sleep released", {31'd0, sdo_en_o}, 32'd0);
      conv_pulse(14'h3333);
      conv_pulse(14'h0444);
      check_mode("R8 sleep holds", 1'b0, 1'b0, 1'b1);
      check("R8 no frame in sleep", {31'd0, sdo_en_o}, 32'd0);
      sck_i = 1'b1;
      wait_n(HOLD);
      check_mode("R9 rising edge wakes", 1'b1, 1'b0, 1'b0);
      sck_i = 1'b0;
      wait_n(HOLD);
      conv_pulse(14'h0555);
      read_frame("R8 held word kept", 14'h2468);
   endtask

   task automatic t_coincide();
      conv_pulse(14'h0011);
      conv_pulse(14'h0022);
      conv_pulse(14'h0033);
      conv_pulse(14'h3A5C);
      check_mode("R10 sleep before", 1'b0, 1'b0, 1'b1);
      sample_i = 14'h1C3E;
      conv_i = 1'b1;
      sck_i = 1'b1;
      wait_n(HOLD);
      check_mode("R10 woke on coincident", 1'b1, 1'b0, 1'b0);
      check("R10 frame opened", {31'd0, sdo_en_o}, 32'd1);
      check("R10 load beats shift", {31'd0, sdo_o}, 32'd1);
      conv_i = 1'b0;
      sck_i = 1'b0;
      wait_n(HOLD);
      read_frame("R10 coincident frame", 14'h3A5C);
      conv_pulse(14'h0000);
      read_frame("R10 coincident sample kept", 14'h1C3E);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_stream();
      t_nap_resume();
      t_nap_wake();
      t_sleep();
      t_coincide();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule